// File: doc/BRIEF.md
# SECDED RAM Error Event Monitor

This block sits between a user read/write port and a 39-bit wide storage array. It protects each 32-bit word with 7 check bits: six Hamming bits and one overall parity bit. Every write is encoded on its way to the array. Every read is checked, and a single flipped bit is repaired before the word is handed back. Two flipped bits are reported but left uncorrected.

Errors found on reads are logged into a small sticky event register. A one-cycle interrupt pulse marks each logged error. Software clears the event register by writing zero to it.

The array's check bits are not initialised by hardware. Software first writes every location and then sets an init-done flag. Until that flag is set, reads are still checked and flagged on the read port, but nothing is logged and no interrupt is raised.

Top module: `secded_ram_mon`

## Requirements
- R1: A write request drives the storage port in the same cycle with a 39-bit word laid out as data in bits [31:0], Hamming bits h[5:0] in bits [37:32], and overall parity in bit 38.
  - Data bit k sits at the k-th codeword position from 1 to 38 that is not a power of two.
  - Hamming bit h[j] is the XOR of the data bits whose position has bit j set.
  - Bit 38 is the XOR of bits [37:0].
- R2: A read request gives rsp_valid exactly one cycle later. A word read back without error returns its data with both error flags low.
- R3: A word with exactly one flipped bit, in any of its 39 bits, returns the original data with rsp_single high and rsp_double low. A flip of the overall parity bit alone also counts as a single-bit error.
- R4: A word with exactly two flipped bits returns the raw, uncorrected data field with rsp_double high and rsp_single low.
- R5: Register address 0 is the event register: bit 0 is set by a logged single-bit error and bit 1 by a logged double-bit error. Set bits stay set and further events OR into them.
- R6: Writing zero to the event register clears it. Writing any non-zero value to it has no effect. An event logged in the same cycle as a clearing write is kept.
- R7: err_irq is high for one cycle, in the cycle after the read response, for each logged error event.
- R8: While init-done is 0, error flags on the read port still work, but the event register is not updated and err_irq stays low.
- R9: After reset the event register and init-done are 0. Register address 1 bit 0 holds init-done and can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | User access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Corrected read data |
| rsp_single | output | 1 | Single-bit error corrected |
| rsp_double | output | 1 | Double-bit error detected |
| mem_en | output | 1 | Storage access enable |
| mem_we | output | 1 | Storage write enable |
| mem_addr | output | ADDR_W | Storage address |
| mem_wdata | output | 39 | Encoded word to storage |
| mem_rdata | input | 39 | Stored word, one cycle after a read |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = event register, 1 = control register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| err_irq | output | 1 | Error interrupt pulse |

## Verification
The bench builds the block with ADDR_W = 4, so that the whole 16-word array can be initialised and revisited in a short run. The data width is fixed at 32, so every one of the 39 single-bit flip positions can be injected into one word. A spread of two-bit flip pairs is also injected, including pairs that touch the parity bit. These pairs give syndromes inside and outside the codeword range. A flip mask held beside the array model corrupts read data without touching the stored word, so clean and faulty reads of the same location can be interleaved.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W  = 32;
    localparam int HAM_W   = 6;
    localparam int CODE_W  = DATA_W + HAM_W + 1;
    localparam int POS_MAX = DATA_W + HAM_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [HAM_W-1:0]  ham_t;

    typedef struct packed {
        logic  par;
        ham_t  ham;
        data_t data;
    } code_t;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_SINGLE = 2'd1,
        ERR_DOUBLE = 2'd2
    } err_e;

    typedef struct packed {
        data_t data;
        err_e  kind;
    } dec_t;

    // Codeword position (1-based) of data bit k: k-th non power of two.
    function automatic int data_pos(int k);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int q = 3; q <= POS_MAX; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (cnt == k) res = q;
                cnt++;
            end
        end
        return res;
    endfunction

    // Hamming bits as the XOR of positions of all set data bits.
    function automatic ham_t calc_ham(data_t d);
        ham_t h;
        h = '0;
        for (int k = 0; k < DATA_W; k++) begin
            if (d[k]) h = h ^ ham_t'(data_pos(k));
        end
        return h;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
(
    input  data_t d_in,
    output code_t cw_out
);
    ham_t h;

    always_comb begin
        h             = calc_ham(d_in);
        cw_out.data   = d_in;
        cw_out.ham    = h;
        cw_out.par    = ^{h, d_in};
    end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
(
    input  code_t cw_in,
    output dec_t  res
);
    ham_t  syn;
    logic  ovr;
    data_t flip;

    assign syn = calc_ham(cw_in.data) ^ cw_in.ham;
    assign ovr = ^cw_in;

    for (genvar k = 0; k < DATA_W; k++) begin : g_flip
        localparam ham_t POS_K = ham_t'(data_pos(k));
        assign flip[k] = (syn == POS_K);
    end

    always_comb begin
        res.data = cw_in.data;
        res.kind = ERR_NONE;
        if (ovr) begin
            if (syn <= ham_t'(POS_MAX)) begin
                res.kind = ERR_SINGLE;
                res.data = cw_in.data ^ flip;
            end else begin
                res.kind = ERR_DOUBLE;
            end
        end else if (syn != '0) begin
            res.kind = ERR_DOUBLE;
        end
    end
endmodule

// File: rtl/secded_evt_regs.sv
module secded_evt_regs
    import secded_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        chk_valid,
    input  err_e        chk_kind,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [1:0]  evt_q,
    output logic        init_q,
    output logic        irq_q
);
    logic [1:0] new_evt;
    logic       clr;

    always_comb begin
        new_evt = 2'b00;
        if (chk_valid && init_q) begin
            new_evt[0] = (chk_kind == ERR_SINGLE);
            new_evt[1] = (chk_kind == ERR_DOUBLE);
        end
    end

    assign clr = reg_wr && !reg_addr && (reg_wdata == 32'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q  <= 2'b00;
            init_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            evt_q <= (clr ? 2'b00 : evt_q) | new_evt;
            irq_q <= |new_evt;
            if (reg_wr && reg_addr) init_q <= reg_wdata[0];
        end
    end

    assign reg_rdata = reg_addr ? {31'd0, init_q} : {30'd0, evt_q};
endmodule

// File: rtl/secded_ram_mon.sv
module secded_ram_mon
    import secded_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_single,
    output logic              rsp_double,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [38:0]       mem_wdata,
    input  logic [38:0]       mem_rdata,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              err_irq
);
    code_t      enc_cw;
    dec_t       dec_res;
    logic       rd_pend;
    logic [1:0] evt_q;
    logic       init_q;

    secded_enc u_enc (
        .d_in   (req_wdata),
        .cw_out (enc_cw)
    );

    secded_dec u_dec (
        .cw_in (code_t'(mem_rdata)),
        .res   (dec_res)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_pend <= 1'b0;
        else     rd_pend <= req_valid && !req_we;
    end

    assign mem_en    = req_valid;
    assign mem_we    = req_we;
    assign mem_addr  = req_addr;
    assign mem_wdata = enc_cw;

    assign rsp_valid  = rd_pend;
    assign rsp_rdata  = dec_res.data;
    assign rsp_single = rd_pend && (dec_res.kind == ERR_SINGLE);
    assign rsp_double = rd_pend && (dec_res.kind == ERR_DOUBLE);

    secded_evt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .chk_valid (rd_pend),
        .chk_kind  (dec_res.kind),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_q     (evt_q),
        .init_q    (init_q),
        .irq_q     (err_irq)
    );
endmodule

// File: rtl/secded_ram_mon_chk.sv
module secded_ram_mon_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_we,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic              rsp_single,
    input logic              rsp_double,
    input logic              mem_en,
    input logic              mem_we,
    input logic [38:0]       mem_wdata,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [1:0]        evt_q,
    input logic              init_q,
    input logic              err_irq
);
    // R1
    wr_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_we) |-> (mem_en && mem_we && mem_wdata[31:0] == req_wdata));

    // R2
    rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we) |=> rsp_valid);

    // R4
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_single && rsp_double));

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(evt_q[0]) || $fell(evt_q[1])) |->
            $past(reg_wr && !reg_addr && reg_wdata == 32'd0));

    // R7
    irq_evt_chk: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> (evt_q != 2'b00));

    // R8
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        !init_q |=> !err_irq);
endmodule

bind secded_ram_mon secded_ram_mon_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_single (rsp_single),
    .rsp_double (rsp_double),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .evt_q      (evt_q),
    .init_q     (init_q),
    .err_irq    (err_irq)
);

// File: tb/secded_ram_mon_tb.sv
`timescale 1ns/1ps
module secded_ram_mon_tb;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, rsp_single, rsp_double;
    logic [31:0]   rsp_rdata;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [38:0]   mem_wdata, mem_rdata;
    logic          reg_wr = 1'b0, reg_addr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          err_irq;

    always #2 clk = ~clk;

    secded_ram_mon #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_single(rsp_single), .rsp_double(rsp_double),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_irq(err_irq)
    );

    // Storage model with a separate fault mask applied on read.
    logic [38:0] mem   [DEPTH];
    logic [38:0] inj   [DEPTH];
    logic [31:0] shadow[DEPTH];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr] ^ inj[mem_addr];
        end
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model: class of pending read (0 none, 1 single, 2 double).
    int         req_cls = 0;
    int         m_cls   = 0;
    logic [1:0] m_evt   = 2'b00;
    logic       m_init  = 1'b0;
    logic       m_irq   = 1'b0;

    always @(posedge clk) begin
        logic [1:0] nw;
        if (rst) begin
            m_evt = 2'b00; m_init = 1'b0; m_irq = 1'b0; m_cls = 0;
        end else begin
            nw = 2'b00;
            if (m_init && m_cls == 1) nw = 2'b01;
            if (m_init && m_cls == 2) nw = 2'b10;
            m_evt = ((reg_wr && !reg_addr && reg_wdata == 32'd0) ? 2'b00 : m_evt) | nw;
            m_irq = (nw != 2'b00);
            if (reg_wr && reg_addr) m_init = reg_wdata[0];
            m_cls = (req_valid && !req_we) ? req_cls : 0;
        end
    end

    // Per-clock comparison of interrupt and register read data (R5 R6 R7 R8 R9).
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        if (!rst) begin
            exp_rd = reg_addr ? {31'd0, m_init} : {30'd0, m_evt};
            checks++;
            if (err_irq !== m_irq) begin
                errors++;
                $display("FAIL R7 err_irq actual %0b expected %0b at %0t", err_irq, m_irq, $time);
            end
            checks++;
            if (reg_rdata !== exp_rd) begin
                errors++;
                $display("FAIL R5/R6/R8 reg_rdata actual %h expected %h at %0t", reg_rdata, exp_rd, $time);
            end
        end
    end

    function automatic logic [38:0] ref_encode(logic [31:0] d);
        logic [5:0] h;
        int k;
        for (int j = 0; j < 6; j++) begin
            h[j] = 1'b0;
            k = 0;
            for (int p = 1; p <= 38; p++) begin
                if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) begin
                    if (((p >> j) & 1) == 1) h[j] = h[j] ^ d[k];
                    k++;
                end
            end
        end
        return {^{h, d}, h, d};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(int a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        shadow[a] = d;
        inj[a] = '0;
        check("R1 stored word", {25'd0, mem[a]}, {25'd0, ref_encode(d)});
    endtask

    task automatic reg_write(logic a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_read(int a, int cls, logic [31:0] exp_d, bit clr_now);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(a); req_cls = cls;
        @(negedge clk);
        req_valid = 1'b0; req_cls = 0;
        check("R2 rsp_valid", 64'(rsp_valid), 64'd1);
        check(cls == 2 ? "R4 data" : "R2/R3 data", 64'(rsp_rdata), 64'(exp_d));
        check("R3 single flag", 64'(rsp_single), 64'(cls == 1));
        check("R4 double flag", 64'(rsp_double), 64'(cls == 2));
        if (clr_now) begin
            reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = '0;
        end
        @(negedge clk);
        reg_wr = 1'b0;
        check("R2 rsp_valid drop", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            inj[i] = '0;
            shadow[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 event reset", 64'(reg_rdata), 64'd0);
        check("R9 rsp_valid reset", 64'(rsp_valid), 64'd0);
        reg_addr = 1'b1;
        @(negedge clk);
        check("R9 init reset", 64'(reg_rdata), 64'd0);
        reg_addr = 1'b0;

        // Initialise every location (R1)
        for (int a = 0; a < DEPTH; a++)
            do_write(a, 32'h9E37_79B9 * (a + 1) ^ {a[7:0], 24'h5A3C1F});
        do_write(0, 32'h0000_0000);
        do_write(1, 32'hFFFF_FFFF);

        // R8 errors before init-done: flagged, not logged
        inj[2] = 39'd1 << 7;
        do_read(2, 1, shadow[2], 1'b0);
        inj[3] = (39'd1 << 3) | (39'd1 << 30);
        do_read(3, 2, shadow[3] ^ 32'h4000_0008, 1'b0);
        check("R8 no event before init", 64'(reg_rdata), 64'd0);

        // R9 init-done
        reg_write(1'b1, 32'd1);
        reg_addr = 1'b1;
        @(negedge clk);
        check("R9 init readback", 64'(reg_rdata), 64'd1);
        reg_addr = 1'b0;

        // R2 clean reads
        for (int a = 0; a < DEPTH; a++) begin
            inj[a] = '0;
            do_read(a, 0, shadow[a], 1'b0);
        end

        // R3 every single flip position
        for (int b = 0; b < 39; b++) begin
            inj[5] = 39'd1 << b;
            do_read(5, 1, shadow[5], 1'b0);
        end
        inj[5] = '0;
        check("R5 single logged", 64'(reg_rdata), 64'd1);

        // R6 non-zero write ignored, zero write clears
        reg_write(1'b0, 32'd3);
        check("R6 nonzero write ignored", 64'(reg_rdata), 64'd1);
        reg_write(1'b0, 32'd0);
        check("R6 cleared", 64'(reg_rdata), 64'd0);

        // R4 double flips
        for (int b = 0; b < 39; b += 3) begin
            logic [38:0] m;
            m = (39'd1 << b) | (39'd1 << ((b + 11) % 39));
            inj[7] = m;
            do_read(7, 2, shadow[7] ^ m[31:0], 1'b0);
        end
        inj[7] = '0;
        check("R5 double logged", 64'(reg_rdata), 64'd2);

        // R5 OR of both kinds
        inj[1] = 39'd1 << 38;
        do_read(1, 1, shadow[1], 1'b0);
        check("R5 both bits", 64'(reg_rdata), 64'd3);

        // R6 clear in same cycle as a new event keeps the event
        reg_write(1'b0, 32'd0);
        inj[0] = 39'd1 << 20;
        do_read(0, 1, shadow[0], 1'b1);
        check("R6 event kept over clear", 64'(reg_rdata), 64'd1);

        // R8 disabling init-done stops logging again
        reg_write(1'b0, 32'd0);
        reg_write(1'b1, 32'd0);
        inj[0] = (39'd1 << 1) | (39'd1 << 2);
        do_read(0, 2, shadow[0] ^ 32'h6, 1'b0);
        check("R8 no log after disable", 64'(reg_rdata), 64'd0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule